// File: doc/BRIEF.md
# Programmable 8-bit Reload Timer

The block is a down-counting timer with a byte-wide register port. Software loads a reload value, then writes a control byte that picks one-shot or continuous operation and a prescale ratio, and sets a run bit. A single-cycle tick input feeds a prescaler. Each full prescale period takes one off the count. In continuous mode, counting below zero reloads from the stored reload value. In one-shot mode the timer parks at zero and clears its run bit by itself, and software can poll that bit.

Writes are locked while the timer runs. The reload value cannot be changed, and a control write can only clear the run bit. If the timer is started again without a fresh reload write, it resumes from the old count less one. The register port has a write strobe, an address and a data byte. Reads are combinational and have no side effects. The port carries no stream data, so there is no valid/ready handshake and no back-pressure: every write is taken in the cycle it is presented.

Top module: `ltmr_top`

## Requirements
- R1: After reset the timer is stopped, and the count, reload and control registers all read 0.
- R2: Address 0 reads the low 8 bits of the count, address 1 the low 8 bits of the reload value, address 2 the control byte, and address 3 reads 0. Writes to addresses 0 and 3 change nothing.
- R3: A reload write (address 1) is taken only while stopped. It loads the count, zeroes the prescale remainder and marks the reload as fresh. A written 0 means a reload of 256, which reads back as 0. A reload write while running is ignored.
- R4: Control bit 0 selects continuous mode (1) or one-shot mode (0), and bit 1 is the run bit, shown on `running_o`. While running, a control write can only change bit 1. Writing 0 to bit 1 stops the timer and discards the fresh-reload mark.
- R5: On start, the prescale divisor is 4^(1+ctrl[5:3]) when ctrl[7:6] = 01, and 4 for any other value of ctrl[7:6].
- R6: On start, the remainder is set to -1, so the first decrement comes after divisor+1 ticks. If no reload was written since the last stop, the count becomes (count-1) mod 256.
- R7: A start in one-shot mode that leaves the count at 0 clears the run bit in the same write.
- R8: A one-shot run from a fresh reload L (1..256) and divisor D keeps the run bit set for 4+L*D ticks. It clears the bit on tick 5+L*D, with the count at 0 and the fresh-reload mark cleared.
- R9: In continuous mode with reload L, the count after n ticks (n ≥ 1) is (L - floor((n-1)/D)) mod (L+1).
- R10: Ticks have no effect while the timer is stopped.
- R11: When a tick and a register write fall in the same cycle, the tick is applied first and the write then acts on the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle count enable feeding the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| running_o | output | 1 | Run bit of the control register |

## Verification
A counting tick can coincide with a control or reload write. Two cases are provoked on purpose. In the first, a continuous run is stopped by a control write in the same cycle as a tick that completes a prescale period; the count read afterwards must already show that decrement. In the second, a reload write lands in the same cycle as the tick on which a one-shot run expires; the write is judged as accepted, because the timer is already stopped once the tick has been applied. Around these cases, the bench sweeps one-shot runs across many reload values and prescale selections and checks each expiry tick against the closed form 5+L*D.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;

  typedef enum logic [1:0] {
    RA_COUNT = 2'd0,
    RA_RELOAD = 2'd1,
    RA_CTRL = 2'd2,
    RA_NONE = 2'd3
  } ltmr_addr_e;

  localparam int CB_CONT = 0;
  localparam int CB_RUN = 1;
  localparam int ONESHOT_TAIL = 4;
  localparam logic [1:0] SEL_SCALED = 2'b01;

endpackage

// File: rtl/ltmr_decode.sv
module ltmr_decode
  import ltmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] count_lo,
  input  logic [DW-1:0] reload_lo,
  input  logic [DW-1:0] ctrl_val,
  output logic          wr_reload,
  output logic          wr_ctrl,
  output logic [DW-1:0] rdata
);

  ltmr_addr_e sel;
  assign sel = ltmr_addr_e'(bus_addr);

  assign wr_reload = bus_wr && (sel == RA_RELOAD);
  assign wr_ctrl = bus_wr && (sel == RA_CTRL);

  always_comb begin
    case (sel)
      RA_COUNT: rdata = count_lo;
      RA_RELOAD: rdata = reload_lo;
      RA_CTRL: rdata = ctrl_val;
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/ltmr_prescale.sv
module ltmr_prescale
  import ltmr_pkg::*;
#(
  parameter int FLD_W = 3,
  parameter int SH_W = 5,
  parameter int REM_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_en,
  input  logic                    start,
  input  logic [1:0]              start_sel,
  input  logic [FLD_W-1:0]        start_fld,
  input  logic                    clr,
  output logic                    step,
  output logic signed [REM_W-1:0] rem_post,
  output logic signed [REM_W-1:0] rem_q
);

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_new;
  logic signed [REM_W-1:0] div_s;
  logic signed [REM_W-1:0] rem_inc;

  // divisor exponent: 2*(1+field) for the scaled selector, else 2 (divide by 4)
  always_comb begin
    if (start_sel == SEL_SCALED) sh_new = SH_W'((32'(start_fld) + 32'd1) << 1);
    else sh_new = SH_W'(2);
  end

  assign div_s = $signed(REM_W'(1) << sh_q);
  assign rem_inc = rem_q + $signed(REM_W'(1));
  assign step = tick_en && (rem_inc >= div_s);

  always_comb begin
    if (!tick_en) rem_post = rem_q;
    else if (step) rem_post = '0;
    else rem_post = rem_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= SH_W'(2);
      rem_q <= '0;
    end else if (start) begin
      sh_q <= sh_new;
      rem_q <= '1;
    end else if (clr) begin
      rem_q <= '0;
    end else begin
      rem_q <= rem_post;
    end
  end

endmodule

// File: rtl/ltmr_counter.sv
module ltmr_counter
  import ltmr_pkg::*;
#(
  parameter int DW = 8,
  parameter int CNT_W = 10,
  parameter int REM_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick_en,
  input  logic                    step,
  input  logic signed [REM_W-1:0] rem_post,
  input  logic                    cont,
  input  logic                    reload_acc,
  input  logic [DW-1:0]           reload_data,
  input  logic                    start,
  input  logic                    stop_req,
  output logic signed [CNT_W-1:0] count_q,
  output logic [DW:0]             reload_q,
  output logic                    fresh_q,
  output logic                    expire,
  output logic                    start_zero
);

  logic signed [CNT_W-1:0] cnt_tick;
  logic signed [CNT_W-1:0] cnt_dec;
  logic signed [CNT_W-1:0] start_val;
  logic signed [CNT_W-1:0] reload_s;
  logic [DW:0] reload_new;
  logic fresh_post;

  assign reload_s = $signed({{(CNT_W-DW-1){1'b0}}, reload_q});
  assign reload_new = (reload_data == '0) ? {1'b1, {DW{1'b0}}} : {1'b0, reload_data};

  // effect of this cycle's tick
  always_comb begin
    cnt_tick = step ? (count_q - $signed(CNT_W'(1))) : count_q;
    expire = 1'b0;
    if (tick_en) begin
      if (cont) begin
        if (cnt_tick < 0) cnt_tick = cnt_tick + reload_s + $signed(CNT_W'(1));
      end else if ((cnt_tick < 0) ||
                   ((cnt_tick == 0) && (rem_post >= $signed(REM_W'(ONESHOT_TAIL))))) begin
        cnt_tick = '0;
        expire = 1'b1;
      end
    end
  end

  assign fresh_post = fresh_q && !expire;
  assign cnt_dec = cnt_tick - $signed(CNT_W'(1));
  assign start_val = fresh_post ? cnt_tick
                                : $signed({{(CNT_W-DW){1'b0}}, cnt_dec[DW-1:0]});
  assign start_zero = (start_val == 0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
      reload_q <= '0;
      fresh_q <= 1'b0;
    end else if (reload_acc) begin
      reload_q <= reload_new;
      count_q <= $signed({{(CNT_W-DW-1){1'b0}}, reload_new});
      fresh_q <= 1'b1;
    end else if (start) begin
      count_q <= start_val;
      fresh_q <= fresh_post;
    end else begin
      count_q <= cnt_tick;
      if (expire || stop_req) fresh_q <= 1'b0;
    end
  end

endmodule

// File: rtl/ltmr_ctrl.sv
module ltmr_ctrl
  import ltmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          expire,
  input  logic          start_zero,
  output logic [DW-1:0] ctrl_q,
  output logic          run_post,
  output logic          start,
  output logic          stop_req
);

  logic [DW-1:0] ctrl_nx;

  assign run_post = ctrl_q[CB_RUN] && !expire;
  assign start = wr_ctrl && !run_post && wdata[CB_RUN];
  assign stop_req = wr_ctrl && run_post && !wdata[CB_RUN];

  always_comb begin
    ctrl_nx = ctrl_q;
    if (expire) ctrl_nx[CB_RUN] = 1'b0;
    if (wr_ctrl) begin
      if (run_post) begin
        ctrl_nx[CB_RUN] = wdata[CB_RUN];
      end else begin
        ctrl_nx = wdata;
        if (start && !wdata[CB_CONT] && start_zero) ctrl_nx[CB_RUN] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else ctrl_q <= ctrl_nx;
  end

endmodule

// File: rtl/ltmr_top.sv
module ltmr_top
  import ltmr_pkg::*;
#(
  parameter int DW = 8,
  parameter int FLD_W = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          running_o
);

  localparam int MAX_SHIFT = 2 * (1 << FLD_W);
  localparam int SH_W = $clog2(MAX_SHIFT + 1);
  localparam int REM_W = MAX_SHIFT + 2;
  localparam int CNT_W = DW + 2;

  logic wr_reload;
  logic wr_ctrl;
  logic [DW-1:0] ctrl_q;
  logic run_post;
  logic start;
  logic stop_req;
  logic tick_en;
  logic step;
  logic signed [REM_W-1:0] rem_post;
  logic signed [REM_W-1:0] rem_q;
  logic signed [CNT_W-1:0] count_q;
  logic [DW:0] reload_q;
  logic fresh_q;
  logic expire;
  logic start_zero;
  logic reload_acc;

  assign tick_en = tick_i && ctrl_q[CB_RUN];
  assign reload_acc = wr_reload && !run_post;
  assign running_o = ctrl_q[CB_RUN];

  ltmr_decode #(.DW(DW)) u_dec (
    .bus_wr(bus_wr),
    .bus_addr(bus_addr),
    .count_lo(count_q[DW-1:0]),
    .reload_lo(reload_q[DW-1:0]),
    .ctrl_val(ctrl_q),
    .wr_reload(wr_reload),
    .wr_ctrl(wr_ctrl),
    .rdata(bus_rdata)
  );

  ltmr_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .wr_ctrl(wr_ctrl),
    .wdata(bus_wdata),
    .expire(expire),
    .start_zero(start_zero),
    .ctrl_q(ctrl_q),
    .run_post(run_post),
    .start(start),
    .stop_req(stop_req)
  );

  ltmr_prescale #(.FLD_W(FLD_W), .SH_W(SH_W), .REM_W(REM_W)) u_pre (
    .clk(clk),
    .rst_n(rst_n),
    .tick_en(tick_en),
    .start(start),
    .start_sel(bus_wdata[7:6]),
    .start_fld(bus_wdata[3 +: FLD_W]),
    .clr(reload_acc),
    .step(step),
    .rem_post(rem_post),
    .rem_q(rem_q)
  );

  ltmr_counter #(.DW(DW), .CNT_W(CNT_W), .REM_W(REM_W)) u_cnt (
    .clk(clk),
    .rst_n(rst_n),
    .tick_en(tick_en),
    .step(step),
    .rem_post(rem_post),
    .cont(ctrl_q[CB_CONT]),
    .reload_acc(reload_acc),
    .reload_data(bus_wdata),
    .start(start),
    .stop_req(stop_req),
    .count_q(count_q),
    .reload_q(reload_q),
    .fresh_q(fresh_q),
    .expire(expire),
    .start_zero(start_zero)
  );

endmodule

// File: rtl/ltmr_chk.sv
module ltmr_chk #(
  parameter int DW = 8,
  parameter int CNT_W = 10,
  parameter int REM_W = 18
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick_i,
  input logic                    bus_wr,
  input logic [1:0]              bus_addr,
  input logic [DW-1:0]           bus_wdata,
  input logic                    running_o,
  input logic [DW-1:0]           ctrl_q,
  input logic signed [CNT_W-1:0] count_q,
  input logic [DW:0]             reload_q,
  input logic                    fresh_q,
  input logic signed [REM_W-1:0] rem_q
);

  AST_RELOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && !tick_i && bus_wr && bus_addr == 2'd1) |=> $stable(reload_q)); // R3

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && bus_wr && bus_addr == 2'd2) |=>
      (ctrl_q[DW-1:2] == $past(ctrl_q[DW-1:2]) && ctrl_q[0] == $past(ctrl_q[0]))); // R4

  AST_STOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (running_o && bus_wr && bus_addr == 2'd2 && !bus_wdata[1]) |=>
      (!running_o && !fresh_q)); // R4

  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(running_o) && !$past(bus_wr)) |-> (count_q == 0 && !fresh_q)); // R8

  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !bus_wr) |=> ($stable(count_q) && $stable(rem_q))); // R10

endmodule

bind ltmr_top ltmr_chk #(.DW(DW), .CNT_W(CNT_W), .REM_W(REM_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .tick_i(tick_i),
  .bus_wr(bus_wr),
  .bus_addr(bus_addr),
  .bus_wdata(bus_wdata),
  .running_o(running_o),
  .ctrl_q(ctrl_q),
  .count_q(count_q),
  .reload_q(reload_q),
  .fresh_q(fresh_q),
  .rem_q(rem_q)
);

// File: tb/sim_ltmr_top.sv
module sim_ltmr_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_i = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic running_o;

  int checks = 0;
  int failures = 0;
  int nt = 0;

  always #10 clk = ~clk;

  ltmr_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .running_o(running_o)
  );

  function automatic int pmod(int a, int m);
    return ((a % m) + m) % m;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #1;
    v = int'(bus_rdata);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic tk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_i = tk;
    @(negedge clk);
    bus_wr = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ticks(int n);
    if (n > 0) begin
      tick_i = 1'b1;
      repeat (n) @(negedge clk);
      tick_i = 1'b0;
    end
  endtask

  task automatic oneshot(int lw, int cv, int d);
    int le;
    int v;
    le = (lw == 0) ? 256 : lw;
    wr(2'd1, 8'(lw), 1'b0);
    wr(2'd2, 8'(cv), 1'b0);
    rd(2'd2, v); chk("R4 ctrl readback", v, cv);
    ticks(4 + le * d);
    chk("R8 running before expiry", int'(running_o), 1);
    rd(2'd0, v); chk("R8 count before expiry", v, 0);
    ticks(1);
    chk("R8 stopped on expiry tick", int'(running_o), 0);
    rd(2'd0, v); chk("R8 count after expiry", v, 0);
    rd(2'd2, v); chk("R5 R8 ctrl after expiry", v, cv & 8'hFD);
  endtask

  initial begin
    #(20 * 190000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v;
    int exp_c;
    int c0;
    int tgt[7] = '{2, 5, 36, 40, 41, 45, 100};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 count", v, 0);
    rd(2'd1, v); chk("R1 reload", v, 0);
    rd(2'd2, v); chk("R1 ctrl", v, 0);
    chk("R1 running", int'(running_o), 0);

    // R2 read-only and unused addresses
    wr(2'd0, 8'h55, 1'b0);
    wr(2'd3, 8'hAA, 1'b0);
    rd(2'd0, v); chk("R2 count not writable", v, 0);
    rd(2'd3, v); chk("R2 unused reads 0", v, 0);
    rd(2'd2, v); chk("R2 ctrl untouched", v, 0);

    // R3, R10 reload while stopped, ticks ignored
    wr(2'd1, 8'd7, 1'b0);
    rd(2'd0, v); chk("R3 reload loads count", v, 7);
    ticks(20);
    rd(2'd0, v); chk("R10 stopped count frozen", v, 7);
    chk("R10 stays stopped", int'(running_o), 0);
    wr(2'd1, 8'd0, 1'b0);
    rd(2'd1, v); chk("R3 reload 0 reads 0", v, 0);

    // R5, R8 one-shot sweep
    for (int l = 1; l <= 12; l++) oneshot(l, 8'h02, 4);
    oneshot(0, 8'h02, 4);
    oneshot(255, 8'h02, 4);
    oneshot(3, 8'h42, 4);
    for (int l = 1; l <= 4; l++) oneshot(l, 8'h4A, 16);
    oneshot(2, 8'h52, 64);
    oneshot(1, 8'h5A, 256);
    oneshot(5, 8'hBA, 4);
    oneshot(2, 8'hFA, 4);

    // R3, R4 locks while running (continuous, reload 9, divide 4)
    wr(2'd1, 8'd9, 1'b0);
    wr(2'd2, 8'h03, 1'b0);
    ticks(2); nt = 2;
    wr(2'd1, 8'h33, 1'b0);
    rd(2'd1, v); chk("R3 reload locked", v, 9);
    rd(2'd0, v); chk("R3 count untouched by locked reload", v, 9);
    wr(2'd2, 8'hFF, 1'b0);
    rd(2'd2, v); chk("R4 mode bits held", v, 8'h03);
    wr(2'd2, 8'h4A, 1'b0);
    rd(2'd2, v); chk("R4 mode bits held 2", v, 8'h03);

    // R9 continuous wrap
    foreach (tgt[i]) begin
      ticks(tgt[i] - nt); nt = tgt[i];
      rd(2'd0, v); chk("R9 continuous count", v, pmod(9 - (nt - 1) / 4, 10));
    end

    // R11 stop write together with a stepping tick
    nt = nt + 1;
    exp_c = pmod(9 - (nt - 1) / 4, 10);
    wr(2'd2, 8'h00, 1'b1);
    rd(2'd0, v); chk("R11 tick before stop", v, exp_c);
    chk("R4 stop clears running", int'(running_o), 0);

    // R6 restart without fresh reload
    c0 = exp_c;
    wr(2'd2, 8'h03, 1'b0);
    rd(2'd0, v); chk("R6 stale count decremented", v, pmod(c0 - 1, 256));
    ticks(4);
    rd(2'd0, v); chk("R6 no step within D ticks", v, pmod(c0 - 1, 256));
    ticks(1);
    rd(2'd0, v); chk("R6 step on tick D+1", v, pmod(c0 - 2, 256));
    wr(2'd2, 8'h00, 1'b0);

    // R7 one-shot start at zero
    wr(2'd1, 8'd1, 1'b0);
    wr(2'd2, 8'h03, 1'b0);
    wr(2'd2, 8'h00, 1'b0);
    wr(2'd2, 8'h02, 1'b0);
    chk("R7 running cleared at once", int'(running_o), 0);
    rd(2'd2, v); chk("R7 ctrl run bit clear", v, 0);
    rd(2'd0, v); chk("R7 count zero", v, 0);
    wr(2'd2, 8'h02, 1'b0);
    rd(2'd0, v); chk("R6 zero wraps to 255", v, 255);
    chk("R6 running after wrap", int'(running_o), 1);
    wr(2'd2, 8'h00, 1'b0);

    // R11 reload write on the expiry tick
    wr(2'd1, 8'd2, 1'b0);
    wr(2'd2, 8'h02, 1'b0);
    ticks(12);
    chk("R11 still running", int'(running_o), 1);
    wr(2'd1, 8'h21, 1'b1);
    chk("R11 expired", int'(running_o), 0);
    rd(2'd1, v); chk("R11 reload accepted after expiry", v, 8'h21);
    rd(2'd0, v); chk("R11 count loaded", v, 8'h21);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule